// File: doc/BRIEF.md
# SPI Register Port with Double-Buffered Commit

This block is a four-wire serial slave that gives a host access to a small register file. Every transaction opens with a 16-bit instruction header, which holds a read/write flag, a length code and a 13-bit register address. One or more data bytes follow the header. The serial pins are sampled by the block's own system clock. Serial-clock edges are found by comparing two successive samples, so the serial clock must stay well below the system clock rate.

Written values land in buffer registers and do not reach the block's outputs at once. A commit command copies every buffer into the active registers in one step, so a group of settings changes together. Reads return the active contents.

A configuration register selects the bit order, MSB-first or LSB-first. The bit order also sets the direction in which the address moves during multi-byte and streaming transfers.

Top module: `spi_shadow_regs`

## Requirements
- R1: The header is 16 bits. Taken in MSB-first order, it is the read flag (1 = read, 0 = write), then a 2-bit length code, then address bits 12 down to 0.
- R2: SDI is sampled on each rising SCLK edge. For a read, each data bit is driven on SDO after a falling SCLK edge. The first data bit appears after the falling edge that follows the 16th rising edge.
- R3: Bit 0 of register 0x000 selects LSB-first order when 1 and MSB-first order when 0. In LSB-first order the whole 16-bit header and every data byte travel least-significant bit first. A change takes effect from the next transaction, and register 0x000 reads back with the selection in bit 0.
- R4: Length code 00 transfers 1 byte, 01 transfers 2 bytes and 10 transfers 3 bytes. Further bytes in the same transaction are ignored. Code 11 streams bytes until chip select rises.
- R5: After each byte of a transaction, the address increments in LSB-first order and decrements in MSB-first order.
- R6: Writes to data registers 0x010 to 0x013 go to buffer registers. The active outputs and read-back values stay unchanged until a commit.
- R7: Writing a byte with bit 0 set to address 0x232 copies all buffer registers into the active registers at once. Register 0x232 always reads 0x00, because the command bit clears itself.
- R8: A write to any other address has no effect, and a read of any other address returns 0x00.
- R9: Chip select high ends the transaction. It clears the bit and byte counters, drops any partial byte without writing it, and holds SDO low.
- R10: After reset, all active registers are 0x00, the bit order is MSB-first and SDO is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| act_q | output | NREG*8 | Active registers; byte i holds register 0x010+i |

## Verification
Each serial pin passes through one sampling register, and edge detection adds one more cycle. As a result, SDO changes two system clocks after a falling SCLK edge, and a commit reaches `act_q` two system clocks after the rising SCLK edge that completes the commit byte. The bench holds each SCLK level for four system clocks. It samples SDO just before it raises SCLK, so every read bit is at least two cycles old. The bench checks `act_q` only after raising chip select and waiting four more clocks, well past the two-cycle settling point.

// File: rtl/spi_shadow_regs.sv
module spi_shadow_regs #(
  parameter int          NREG     = 4,
  parameter logic [12:0] BASE     = 13'h010,
  parameter logic [12:0] UPD_ADDR = 13'h232,
  parameter logic [12:0] CFG_ADDR = 13'h000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            sdi,
  output logic            sdo,
  output logic [NREG*8-1:0] act_q
);
  logic s0, s1, csq, dq;
  logic lsb_cur, cfg_lsb, hdr_done, done, rw, stream;
  logic [1:0]  left;
  logic [12:0] addr;
  logic [3:0]  cnt;
  logic [15:0] sh;
  logic [7:0]  tx, rdv;
  logic [7:0]  bufr [NREG];
  logic [7:0]  act  [NREG];

  wire rise = s0 & ~s1 & ~csq;
  wire fall = ~s0 & s1 & ~csq;
  wire [15:0] nxt   = lsb_cur ? {dq, sh[15:1]} : {sh[14:0], dq};
  wire [7:0]  wbyte = lsb_cur ? nxt[15:8] : nxt[7:0];

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign act_q[g*8 +: 8] = act[g];
  end

  always_comb begin
    rdv = 8'h00;
    if (addr == CFG_ADDR) rdv = {7'b0, cfg_lsb};
    for (int i = 0; i < NREG; i++)
      if (addr == BASE + 13'(i)) rdv = act[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0; s1 <= 1'b0; csq <= 1'b1; dq <= 1'b0;
      lsb_cur <= 1'b0; cfg_lsb <= 1'b0; hdr_done <= 1'b0; done <= 1'b0;
      rw <= 1'b0; stream <= 1'b0; left <= '0; addr <= '0; cnt <= '0;
      sh <= '0; tx <= '0; sdo <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        bufr[i] <= 8'h00;
        act[i]  <= 8'h00;
      end
    end else begin
      s0 <= sclk; s1 <= s0; csq <= cs_n; dq <= sdi;
      if (csq) begin
        hdr_done <= 1'b0; done <= 1'b0; cnt <= '0; sh <= '0;
        sdo <= 1'b0; lsb_cur <= cfg_lsb;
      end else begin
        if (rise && !done) begin
          sh  <= nxt;
          cnt <= cnt + 4'd1;
          if (!hdr_done) begin
            if (cnt == 4'd15) begin
              hdr_done <= 1'b1;
              rw       <= nxt[15];
              stream   <= &nxt[14:13];
              left     <= nxt[14:13];
              addr     <= nxt[12:0];
            end
          end else if (cnt[2:0] == 3'd7) begin
            cnt <= '0;
            if (!rw) begin
              if (addr == CFG_ADDR) cfg_lsb <= wbyte[0];
              else if (addr == UPD_ADDR) begin
                if (wbyte[0])
                  for (int i = 0; i < NREG; i++) act[i] <= bufr[i];
              end else begin
                for (int i = 0; i < NREG; i++)
                  if (addr == BASE + 13'(i)) bufr[i] <= wbyte;
              end
            end
            addr <= lsb_cur ? addr + 13'd1 : addr - 13'd1;
            if (!stream) begin
              if (left == 2'd0) done <= 1'b1;
              else left <= left - 2'd1;
            end
          end
        end
        if (fall && hdr_done && rw && !done) begin
          if (cnt[2:0] == 3'd0) begin
            sdo <= lsb_cur ? rdv[0] : rdv[7];
            tx  <= lsb_cur ? {1'b0, rdv[7:1]} : {rdv[6:0], 1'b0};
          end else begin
            sdo <= lsb_cur ? tx[0] : tx[7];
            tx  <= lsb_cur ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module spi_shadow_regs_chk #(parameter int W = 32) (
  input logic         clk,
  input logic         rst_n,
  input logic         csq,
  input logic         rise,
  input logic         fall,
  input logic         done,
  input logic         sdo,
  input logic         lsb_cur,
  input logic [W-1:0] act_q
);
  a_r9_sdo_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csq |=> (sdo == 1'b0));
  a_r2_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !csq) |=> $stable(sdo));
  a_r7_commit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(act_q));
  a_r3_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    !csq |=> $stable(lsb_cur));
  a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !csq) |=> ($stable(sdo) && $stable(act_q)));
endmodule

bind spi_shadow_regs spi_shadow_regs_chk #(.W(NREG*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .csq(csq), .rise(rise), .fall(fall),
  .done(done), .sdo(sdo), .lsb_cur(lsb_cur), .act_q(act_q));

// File: tb/spi_shadow_regs_test.sv
`timescale 1ns/1ps
module spi_shadow_regs_test;
  localparam int HALF = 4;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, sdi = 0;
  logic sdo;
  logic [31:0] act_q;
  int vecs = 0, miss = 0;
  bit fin = 0;

  spi_shadow_regs uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                       .sdi(sdi), .sdo(sdo), .act_q(act_q));

  always #2.5 clk = ~clk;

  // {addr, write data, expected read-back after commit}
  localparam logic [28:0] VEC [6] = '{
    {13'h0010, 8'hA5, 8'hA5}, {13'h0011, 8'h3C, 8'h3C},
    {13'h0013, 8'hFF, 8'hFF}, {13'h0020, 8'h77, 8'h00},
    {13'h1FFF, 8'h12, 8'h00}, {13'h0012, 8'h81, 8'h81}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    @(negedge clk) sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sclk = 1;
    repeat (HALF) @(negedge clk);
    sclk = 0;
  endtask

  task automatic xbyte(input logic lsb, input logic [7:0] d, output logic [7:0] r);
    logic rb;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      xbit(d[idx], rb);
      r[idx] = rb;
    end
  endtask

  task automatic xhdr(input logic lsb, input logic rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] v;
    logic rb;
    v = {rw, len, a};
    for (int i = 0; i < 16; i++) xbit(v[lsb ? i : 15 - i], rb);
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic lsb, input logic [12:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo(); xhdr(lsb, 1'b0, 2'b00, a); xbyte(lsb, d, r); cs_hi();
  endtask

  task automatic rd1(input logic lsb, input logic [12:0] a, output logic [7:0] d);
    cs_lo(); xhdr(lsb, 1'b1, 2'b00, a); xbyte(lsb, 8'h00, d); cs_hi();
  endtask

  task automatic commit(input logic lsb);
    wr1(lsb, 13'h232, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R10 active after reset", act_q, 32'h0);
    chk("R10 sdo after reset", {31'b0, sdo}, 32'h0);

    // table: R1 header, R6/R7 commit, R8 unused addresses
    foreach (VEC[k]) begin
      wr1(1'b0, VEC[k][28:16], VEC[k][15:8]);
      commit(1'b0);
      rd1(1'b0, VEC[k][28:16], r);
      chk("R1/R8 table read-back", {24'b0, r}, {24'b0, VEC[k][7:0]});
    end
    chk("R7 active after table", act_q, 32'hFF813CA5);

    // R6 shadow: no change before commit
    wr1(1'b0, 13'h010, 8'h5A);
    chk("R6 active before commit", act_q, 32'hFF813CA5);
    rd1(1'b0, 13'h010, r);
    chk("R6 read-back before commit", {24'b0, r}, 32'hA5);
    commit(1'b0);
    chk("R7 active after commit", act_q, 32'hFF813C5A);
    rd1(1'b0, 13'h232, r);
    chk("R7 commit register reads zero", {24'b0, r}, 32'h0);

    // R4/R5 MSB-first three bytes, descending, fourth byte ignored
    cs_lo(); xhdr(1'b0, 1'b0, 2'b10, 13'h013);
    xbyte(1'b0, 8'h01, r); xbyte(1'b0, 8'h02, r); xbyte(1'b0, 8'h03, r);
    xbyte(1'b0, 8'h04, r);
    cs_hi(); commit(1'b0);
    chk("R4/R5 MSB-first 3-byte write", act_q, 32'h0102035A);

    cs_lo(); xhdr(1'b0, 1'b1, 2'b01, 13'h012);
    xbyte(1'b0, 8'h00, r); xbyte(1'b0, 8'h00, r2);
    cs_hi();
    chk("R2/R5 MSB-first read byte 1", {24'b0, r}, 32'h02);
    chk("R2/R5 MSB-first read byte 2", {24'b0, r2}, 32'h03);

    // R3: select LSB-first, then stream ascending
    wr1(1'b0, 13'h000, 8'h01);
    cs_lo(); xhdr(1'b1, 1'b0, 2'b11, 13'h010);
    xbyte(1'b1, 8'h11, r); xbyte(1'b1, 8'h22, r);
    xbyte(1'b1, 8'h33, r); xbyte(1'b1, 8'h44, r);
    cs_hi(); commit(1'b1);
    chk("R3/R4/R5 LSB-first stream write", act_q, 32'h44332211);
    rd1(1'b1, 13'h000, r);
    chk("R3 order register read-back", {24'b0, r}, 32'h01);

    // R9 abort mid-byte
    cs_lo(); xhdr(1'b1, 1'b0, 2'b00, 13'h011);
    for (int i = 0; i < 5; i++) xbit(1'b1, r[0]);
    cs_hi();
    chk("R9 sdo low while deselected", {31'b0, sdo}, 32'h0);
    commit(1'b1);
    chk("R9 partial byte not written", act_q, 32'h44332211);
    rd1(1'b1, 13'h011, r);
    chk("R9 counters reset after abort", {24'b0, r}, 32'h22);

    // R8 unused address in LSB-first order
    wr1(1'b1, 13'h005, 8'h99);
    commit(1'b1);
    rd1(1'b1, 13'h005, r);
    chk("R8 unused reads zero", {24'b0, r}, 32'h0);
    chk("R8 unused write no effect", act_q, 32'h44332211);

    // R3 back to MSB-first
    wr1(1'b1, 13'h000, 8'h00);
    rd1(1'b0, 13'h013, r);
    chk("R3 MSB-first restored", {24'b0, r}, 32'h44);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule